// File: doc/BRIEF.md
# Sense-Reversing Barrier Unit

This block holds a group of `NPART` participants at a barrier until every one of them has arrived. Each participant signals its arrival with a one-cycle pulse on its `arrive` bit. The block keeps a private phase bit for each participant, one shared arrival counter and one shared release phase. An accepted arrival inverts that participant's private phase and adds to the counter. Arrivals in the same cycle are all counted in that cycle. When the arrivals bring the counter to `NPART`, the counter goes back to zero and the shared phase takes the new private value. That opens the barrier.

A participant's `done` bit is high whenever its private phase matches the shared phase. After an arrival the bit reads "still waiting" until the release. The phase alternates from one episode to the next, so the same counter and shared phase serve the next barrier at once. A participant that leaves late cannot block the next episode. An arrival pulse from a participant that is still waiting breaks the protocol. The block flags it and otherwise ignores that pulse.

Episode control is a two-state machine:
- State `EP_IDLE`: the counter is zero.
- State `EP_GATHER`: the counter is between 1 and `NPART-1`.
- Transition "first arrivals" (`EP_IDLE` to `EP_GATHER`): some arrivals are accepted but they do not complete the group.
- Transition "burst release" (`EP_IDLE` to `EP_IDLE`): all participants arrive in one cycle.
- Transition "final arrival" (`EP_GATHER` to `EP_IDLE`): the arrivals bring the count to `NPART`.
- Transition "hold" (self loop in either state): no arrival is accepted, or the group stays incomplete while gathering.

Top module: `sense_barrier`

## Requirements
- R1: An arrive pulse on a participant whose `done` is high is accepted. It inverts that participant's private phase at the next clock edge, so `done` for that participant reads 0 from the next cycle until the release. The exception is an arrival that completes the group.
- R2: All arrivals accepted in one cycle are added to the counter in that cycle, whatever their number. The counter never reaches `NPART`.
- R3: When the accepted arrivals bring the counter to exactly `NPART`, the counter returns to zero. At the same edge `shared_phase` inverts to the participants' new phase value. Otherwise `shared_phase` holds its value.
- R4: For every participant, `done[i]` is 1 exactly when its private phase equals `shared_phase`. All participants therefore read `done`=1 from the cycle after the release, and a participant whose arrival completes the group never sees `done` drop.
- R5: A participant may arrive again in the first cycle after a release. The new episode then completes normally, with no stall from the previous one.
- R6: An arrive pulse on a participant whose `done` is 0 sets `proto_err` for that participant for one cycle, from the next cycle. The pulse changes neither its phase nor the counter.
- R7: After reset the counter is zero, `shared_phase` is 0 and every private phase is 0. As a result every `done` bit is 1 and `proto_err` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| arrive | input | NPART | One-cycle arrival pulse per participant |
| done | output | NPART | 1 when the participant's phase equals the shared phase |
| proto_err | output | NPART | One-cycle flag for an arrival while waiting |
| shared_phase | output | 1 | Current shared release phase |

## Verification
The assertions check, on every cycle:
- the counter stays below the group size;
- the counter is zero exactly when the machine is in `EP_IDLE`;
- the shared phase changes only at a completion;
- accepted arrivals flip their phase and rejected ones do not.

Only the bench's scenarios can show the behaviour across whole episodes:
- the release of the whole group;
- the last arriver keeping `done` high;
- an immediate re-arrival after a release;
- the error flag on an early arrival.

The bench compares all of these against a reference model.

// File: rtl/barrier_pkg.sv
package barrier_pkg;
    typedef enum logic [0:0] {
        EP_IDLE   = 1'b0,
        EP_GATHER = 1'b1
    } ep_state_t;
endpackage

// File: rtl/arrival_popcnt.sv
module arrival_popcnt #(
    parameter int NPART = 4,
    localparam int SW = $clog2(NPART + 1)
) (
    input  logic [NPART-1:0] bits,
    output logic [SW-1:0]    count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < NPART; i++) begin
            count = count + SW'(bits[i]);
        end
    end
endmodule

// File: rtl/sense_bank.sv
module sense_bank #(
    parameter int NPART = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPART-1:0] arrive,
    input  logic             phase,
    output logic [NPART-1:0] done,
    output logic [NPART-1:0] accept,
    output logic [NPART-1:0] proto_err
);
    logic [NPART-1:0] sense_q;
    logic [NPART-1:0] err_q;

    assign done   = ~(sense_q ^ {NPART{phase}});
    assign accept = arrive & done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sense_q <= '0;
            err_q   <= '0;
        end else begin
            sense_q <= sense_q ^ accept;
            err_q   <= arrive & ~done;
        end
    end

    assign proto_err = err_q;

    // R1: accepted arrivals invert their phase bit
    a_r1_flip_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (accept != '0) |=> ((sense_q & $past(accept)) == (~$past(sense_q) & $past(accept))));

    // R6: rejected arrivals leave their phase bit unchanged
    a_r6_reject_no_flip: assert property (@(posedge clk) disable iff (!rst_n)
        ((arrive & ~done) != '0) |=> ((sense_q & $past(arrive & ~done)) == ($past(sense_q) & $past(arrive & ~done))));

    // R6: error flag never set on a participant that did not pulse
    a_r6_err_needs_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((proto_err & ~$past(arrive)) == '0));
endmodule

// File: rtl/episode_ctrl.sv
module episode_ctrl
    import barrier_pkg::*;
#(
    parameter int NPART = 4,
    localparam int SW   = $clog2(NPART + 1),
    localparam int SUMW = SW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] arr_cnt,
    output logic          phase,
    output logic          complete
);
    ep_state_t     state_q, state_d;
    logic [SW-1:0] cnt_q;
    logic          phase_q;
    logic [SUMW-1:0] sum;

    assign sum      = SUMW'(cnt_q) + SUMW'(arr_cnt);
    assign complete = (sum == SUMW'(NPART));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EP_IDLE: begin
                if (complete)           state_d = EP_IDLE;
                else if (arr_cnt != '0) state_d = EP_GATHER;
            end
            EP_GATHER: begin
                if (complete) state_d = EP_IDLE;
            end
            default: state_d = EP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (complete) begin
            cnt_q   <= '0;
            phase_q <= ~phase_q;
        end else begin
            cnt_q   <= sum[SW-1:0];
        end
    end

    assign phase = phase_q;

    a_r2_count_below_group: assert property (@(posedge clk) disable iff (!rst_n)
        SUMW'(cnt_q) < SUMW'(NPART));

    a_r2_idle_iff_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EP_IDLE) == (cnt_q == '0));

    a_r3_flip_on_complete: assert property (@(posedge clk) disable iff (!rst_n)
        complete |=> (phase_q != $past(phase_q)));

    a_r3_hold_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        !complete |=> $stable(phase_q));
endmodule

// File: rtl/sense_barrier.sv
module sense_barrier #(
    parameter int NPART = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPART-1:0] arrive,
    output logic [NPART-1:0] done,
    output logic [NPART-1:0] proto_err,
    output logic             shared_phase
);
    localparam int SW = $clog2(NPART + 1);

    logic [NPART-1:0] accept;
    logic [SW-1:0]    arr_cnt;
    logic             phase;
    logic             complete;

    sense_bank #(.NPART(NPART)) bank_i (
        .clk(clk), .rst_n(rst_n), .arrive(arrive), .phase(phase),
        .done(done), .accept(accept), .proto_err(proto_err)
    );

    arrival_popcnt #(.NPART(NPART)) pop_i (
        .bits(accept), .count(arr_cnt)
    );

    episode_ctrl #(.NPART(NPART)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .arr_cnt(arr_cnt),
        .phase(phase), .complete(complete)
    );

    assign shared_phase = phase;

    // R4: after a completion every participant reads done
    a_r4_all_done_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        complete |=> (done == '1));
endmodule

// File: tb/sense_barrier_tb_top.sv
module sense_barrier_tb_top;
    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] arrive = '0;
    logic [NP-1:0] done;
    logic [NP-1:0] proto_err;
    logic          shared_phase;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    logic [NP-1:0] sense_m = '0;
    logic          flag_m  = 1'b0;
    int            cnt_m   = 0;
    logic [NP-1:0] err_m   = '0;

    always #4 clk = ~clk;

    sense_barrier #(.NPART(NP)) dut_i (
        .clk(clk), .rst_n(rst_n), .arrive(arrive), .done(done),
        .proto_err(proto_err), .shared_phase(shared_phase)
    );

    function automatic logic [NP-1:0] exp_done();
        return ~(sense_m ^ {NP{flag_m}});
    endfunction

    task automatic check(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check({tag, " done"}, done, exp_done());
        check("R6 proto_err", proto_err, err_m);
        check("R3 shared_phase", {{(NP-1){1'b0}}, shared_phase}, {{(NP-1){1'b0}}, flag_m});
    endtask

    task automatic step(input logic [NP-1:0] arr, input string tag);
        logic [NP-1:0] dm;
        logic [NP-1:0] acc;
        dm  = exp_done();
        acc = arr & dm;
        err_m   = arr & ~dm;
        sense_m = sense_m ^ acc;
        cnt_m   = cnt_m + $countones(acc);
        if (cnt_m == NP) begin
            cnt_m  = 0;
            flag_m = ~flag_m;
        end
        arrive = arr;
        @(posedge clk);
        @(negedge clk);
        arrive = '0;
        check_all(tag);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [NP-1:0] r;
        int unsigned seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 reset done", done, '1);
        check("R7 reset proto_err", proto_err, '0);
        check("R7 reset phase", {{(NP-1){1'b0}}, shared_phase}, '0);

        // one at a time: R1 done drops, last arriver keeps done (R4)
        step(4'b0001, "R1");
        check("R1 p0 waiting", {{(NP-1){1'b0}}, done[0]}, '0);
        step(4'b0010, "R1");
        step(4'b0100, "R1");
        step(4'b1000, "R4");
        check("R4 all released", done, '1);

        // simultaneous arrivals, R2
        step(4'b0011, "R2");
        step(4'b1100, "R2");
        check("R2 pair release", done, '1);
        step(4'b1111, "R2");
        check("R2 burst release", done, '1);

        // protocol error: R6
        step(4'b0001, "R6");
        step(4'b0001, "R6");
        check("R6 flagged", proto_err, 4'b0001);
        step(4'b1110, "R6");
        check("R6 counter unaffected", done, '1);

        // back-to-back: R5
        step(4'b0111, "R5");
        step(4'b1000, "R5");
        step(4'b1111, "R5");
        step(4'b1111, "R5");
        check("R5 immediate reuse", done, '1);

        for (int k = 0; k < 400; k++) begin
            logic [NP-1:0] d;
            d = exp_done();
            r = '0;
            for (int i = 0; i < NP; i++) begin
                if (d[i]) r[i] = ($urandom % 3) == 0;
                else      r[i] = ($urandom % 16) == 0;
            end
            step(r, "R4");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule